// File: doc/BRIEF.md
# Paged Open-Drain GPIO Controller with Edge Interrupts

This block is a 48-line parallel I/O controller that a host reaches through a 16-byte, byte-wide register window. The lines are grouped into six 8-bit ports. Each line is open-drain and controlled by an inverted data bit: a set bit pulls the pad low, and a clear bit lets an external pull-up hold it high, so the same line also serves as an input. A read of a port returns the inverted, synchronised level of its pads.

The lowest 24 lines (ports 0 to 2) can raise edge interrupts. A page field in the control register at offset 7 chooses what the three offsets 8 to 10 expose: per-line edge polarity, per-line enable, or the latched event flags. Software reads the flags and writes zeros to acknowledge them. A per-port lock mask in the same control register blocks writes to port data. A level interrupt output is high while any flag is latched.

Top module: `pgio_ctrl`

## Requirements
- R1: After a synchronous reset every pad is released (`pad_drive_low` all zero), `irq` is low, the control register at offset 7 reads 0, and the polarity, enable and flag banks read 0 on pages 1, 2 and 3.
- R2: Writing a byte to offset p (0 to 5) of an unlocked port sets `pad_drive_low[8p+7:8p]` to that byte from the next cycle on; a 1 pulls the pad low, a 0 releases it.
- R3: A read of offset p (0 to 5) returns the bitwise inverse of `pad_in[8p+7:8p]` after two synchroniser stages; `bus_rdata` is registered, valid the cycle after `bus_rd`, and holds its value when no read is made.
- R4: Offset 7 holds the page in bits 7:6 and port lock bits in bits 5:0 (bit p locks port p) and reads back as written; port offsets 0 to 5 behave the same on every page.
- R5: While lock bit p is set, writes to offset p leave that port's drive unchanged.
- R6: Offsets 8, 9 and 10 map to ports 0, 1 and 2 of the bank chosen by the page: 1 is polarity, 2 is enable, 3 is flags. On page 0 they read 0 and writes have no effect; offsets 11 to 15 always read 0.
- R7: An enabled line in ports 0 to 2 sets its flag on a rising edge when its polarity bit is 1 and on a falling edge when it is 0; the opposite edge, or a disabled line, sets nothing. Edges made by the block's own drive count too.
- R8: Writing the flag bank (page 3) clears each flag whose written bit is 0 and keeps each whose bit is 1; `irq` falls when the last flag clears.
- R9: When a flag-clearing write and a new qualifying edge on the same line fall on the same cycle, the flag ends set; other bits cleared by that write stay clear.
- R10: Offset 6 reads the OR of each interrupt port's flags in bits 2:0 (bit p for port p) with bits 7:3 zero, and `irq` is high exactly while any flag is set.
- R11: Lines 24 to 47 never set a flag or raise `irq`, whatever their pads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pad levels as seen at the pins |
| pad_drive_low | output | 48 | 1 enables the open-drain pull-down of a pad |
| irq | output | 1 | Level interrupt, high while any flag is set |

## Verification
The two functions that can coincide are the acknowledge write to the flag bank and the latching of a fresh edge on a line in that bank. The bench changes a pad level and then times the clearing write so that it is sampled on the very edge where the synchronised edge reaches the flag register, counting both synchroniser stages and the previous-level register. It judges the outcome by reading the flag bank and `irq` afterwards: the freshly hit line must remain set while a second flag cleared by the same write must be gone.

// File: rtl/pgio_pkg.sv
package pgio_pkg;
  // Fixed offsets inside the register window.
  localparam int OFS_PEND = 6;
  localparam int OFS_CTRL = 7;
  localparam int OFS_BANK = 8;

  // Page field values selecting the bank at OFS_BANK and above.
  typedef enum logic [1:0] {
    PG_PLAIN = 2'd0,
    PG_POL   = 2'd1,
    PG_EN    = 2'd2,
    PG_FLAG  = 2'd3
  } page_e;
endpackage

// File: rtl/pgio_sync.sv
module pgio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  // Idle pads float high through the pull-up, so reset to ones.
  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgio_edge_port.sv
module pgio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] flag_nxt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] hit;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign hit  = en & ((pol & rise) | (~pol & fall));

  // A new hit is ORed in after the acknowledge mask, so it survives.
  assign flag_nxt = (clr_we ? (flag_q & clr_keep) : flag_q) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '1;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/pgio_rdmux.sv
module pgio_rdmux
  import pgio_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4,
  localparam int NUM_LINES = NUM_PORTS * PORT_W,
  localparam int IRQ_LINES = IRQ_PORTS * PORT_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  page_e                page,
  input  logic [NUM_PORTS-1:0] lock,
  input  logic [NUM_LINES-1:0] pin_s,
  input  logic [IRQ_LINES-1:0] pol,
  input  logic [IRQ_LINES-1:0] en,
  input  logic [IRQ_LINES-1:0] flag,
  output logic [PORT_W-1:0]    val
);
  logic [IRQ_PORTS-1:0] pend;
  logic [PORT_W-3:0]    lock_ext;

  always_comb begin
    for (int p = 0; p < IRQ_PORTS; p++) pend[p] = |flag[p*PORT_W +: PORT_W];
    lock_ext = '0;
    lock_ext[NUM_PORTS-1:0] = lock;
  end

  always_comb begin
    val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(p)) val = ~pin_s[p*PORT_W +: PORT_W];
    end
    if (addr == ADDR_W'(OFS_PEND)) val = PORT_W'(pend);
    if (addr == ADDR_W'(OFS_CTRL)) val = {page, lock_ext};
    for (int p = 0; p < IRQ_PORTS; p++) begin
      if (addr == ADDR_W'(OFS_BANK + p)) begin
        case (page)
          PG_POL:  val = pol[p*PORT_W +: PORT_W];
          PG_EN:   val = en[p*PORT_W +: PORT_W];
          PG_FLAG: val = flag[p*PORT_W +: PORT_W];
          default: val = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgio_ctrl.sv
module pgio_ctrl
  import pgio_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int IRQ_PORTS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  localparam int NUM_LINES  = NUM_PORTS * PORT_W,
  localparam int IRQ_LINES  = IRQ_PORTS * PORT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PORT_W-1:0]    bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [PORT_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_drive_low,
  output logic                 irq
);
  logic [NUM_LINES-1:0] data_q;
  logic [NUM_PORTS-1:0] lock_q;
  page_e                page_q;
  logic [IRQ_LINES-1:0] pol_q;
  logic [IRQ_LINES-1:0] en_q;
  logic [IRQ_LINES-1:0] flag_q;
  logic [IRQ_LINES-1:0] flag_nxt;
  logic [NUM_LINES-1:0] pin_s;
  logic [IRQ_PORTS-1:0] bank_we;
  logic [PORT_W-1:0]    rd_val;
  logic [PORT_W-1:0]    rdata_q;
  logic                 irq_q;

  // Port data registers, one per port, gated by the lock mask.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        data_q[p*PORT_W +: PORT_W] <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(p) && !lock_q[p])
        data_q[p*PORT_W +: PORT_W] <= bus_wdata;
    end
  end

  // Control register: page select on top, lock bits at the bottom.
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= PG_PLAIN;
      lock_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) begin
      page_q <= page_e'(bus_wdata[PORT_W-1 -: 2]);
      lock_q <= bus_wdata[NUM_PORTS-1:0];
    end
  end

  pgio_sync #(
    .W      (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_s)
  );

  // Interrupt-capable ports: paged polarity/enable banks plus flag latch.
  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq_port
    assign bank_we[p] = bus_wr && (bus_addr == ADDR_W'(OFS_BANK + p));

    always_ff @(posedge clk) begin
      if (rst) begin
        pol_q[p*PORT_W +: PORT_W] <= '0;
        en_q[p*PORT_W +: PORT_W]  <= '0;
      end else if (bank_we[p]) begin
        if (page_q == PG_POL) pol_q[p*PORT_W +: PORT_W] <= bus_wdata;
        if (page_q == PG_EN)  en_q[p*PORT_W +: PORT_W]  <= bus_wdata;
      end
    end

    pgio_edge_port #(
      .W (PORT_W)
    ) u_edge (
      .clk      (clk),
      .rst      (rst),
      .lvl      (pin_s[p*PORT_W +: PORT_W]),
      .pol      (pol_q[p*PORT_W +: PORT_W]),
      .en       (en_q[p*PORT_W +: PORT_W]),
      .clr_we   (bank_we[p] && page_q == PG_FLAG),
      .clr_keep (bus_wdata),
      .flag_q   (flag_q[p*PORT_W +: PORT_W]),
      .flag_nxt (flag_nxt[p*PORT_W +: PORT_W])
    );
  end

  // Registered interrupt tracks the flag register in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |flag_nxt;
  end

  pgio_rdmux #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .IRQ_PORTS (IRQ_PORTS),
    .ADDR_W    (ADDR_W)
  ) u_rdmux (
    .addr  (bus_addr),
    .page  (page_q),
    .lock  (lock_q),
    .pin_s (pin_s),
    .pol   (pol_q),
    .en    (en_q),
    .flag  (flag_q),
    .val   (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata     = rdata_q;
  assign pad_drive_low = data_q;
  assign irq           = irq_q;
endmodule

// File: rtl/pgio_ctrl_chk.sv
module pgio_ctrl_chk #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4,
  localparam int NUM_LINES = NUM_PORTS * PORT_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [PORT_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] pad_drive_low,
  input logic                 irq,
  input logic [NUM_PORTS-1:0] lock_q,
  input logic [1:0]           page_q
);
  // R1: leaving reset, pads are released and no interrupt is raised.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_drive_low == '0 && !irq));

  // R2: the pad drive only moves after a write.
  p_drive_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(pad_drive_low));

  // R3: read data holds unless a read was strobed.
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R5: a write to a locked port leaves its drive untouched.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lock
    p_locked_port_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(p) && lock_q[p])
      |=> $stable(pad_drive_low[p*PORT_W +: PORT_W]));
  end

  // R8: the interrupt can only drop after a write to the flag bank.
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(bus_wr && page_q == 2'd3 &&
                         bus_addr >= ADDR_W'(8) &&
                         bus_addr < ADDR_W'(8 + IRQ_PORTS)));
endmodule

bind pgio_ctrl pgio_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .IRQ_PORTS (IRQ_PORTS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .pad_drive_low (pad_drive_low),
  .irq           (irq),
  .lock_q        (lock_q),
  .page_q        (page_q)
);

// File: tb/sim_pgio_ctrl.sv
module sim_pgio_ctrl;
  localparam int NL = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_rdata;
  logic [NL-1:0] pad_in;
  logic [NL-1:0] pad_drive_low;
  logic          irq;
  logic [NL-1:0] ext_lvl = '1;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic       rd_seen = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  // Open-drain pad: pull-up unless the block or the outside pulls low.
  assign pad_in = ext_lvl & ~pad_drive_low;

  pgio_ctrl u0 (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .pad_in        (pad_in),
    .pad_drive_low (pad_drive_low),
    .irq           (irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one write per call, starting and ending on a falling edge.
  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: queue the expected byte and strobe a read.
  task automatic rd_exp(logic [3:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare the registered read data one cycle after the strobe.
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_fail++;
        $display("FAIL scoreboard: actual %0h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 drive", 64'(pad_drive_low), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    rd_exp(4'h7, 8'h00, "R1 ctrl");
    wr(4'h7, 8'h40);
    rd_exp(4'h8, 8'h00, "R1 pol0");
    rd_exp(4'ha, 8'h00, "R1 pol2");
    wr(4'h7, 8'h80);
    rd_exp(4'h9, 8'h00, "R1 en1");
    wr(4'h7, 8'hc0);
    rd_exp(4'h8, 8'h00, "R1 flag0");

    // R2: drive follows written bits
    wr(4'h0, 8'ha5);
    chk("R2 port0 drive", 64'(pad_drive_low[7:0]), 64'ha5);
    wr(4'h5, 8'h3c);
    chk("R2 port5 drive", 64'(pad_drive_low[47:40]), 64'h3c);
    wr(4'h0, 8'h00);
    chk("R2 port0 release", 64'(pad_drive_low[7:0]), 64'h00);

    // R3: inverted synchronised pin level
    ext_lvl[15:8] = 8'h0f;
    idle(3);
    rd_exp(4'h1, 8'hf0, "R3 port1 external");
    rd_exp(4'h5, 8'h3c, "R3 port5 own drive");

    // R4: control register read-back, ports reachable on any page
    wr(4'h7, 8'h40);
    rd_exp(4'h7, 8'h40, "R4 ctrl");
    rd_exp(4'h5, 8'h3c, "R4 port5 on page1");

    // R5: locked port ignores writes
    wr(4'h7, 8'h42);
    rd_exp(4'h7, 8'h42, "R4 ctrl lock");
    wr(4'h1, 8'hff);
    chk("R5 locked port1", 64'(pad_drive_low[15:8]), 64'h00);
    wr(4'h2, 8'h11);
    chk("R5 unlocked port2", 64'(pad_drive_low[23:16]), 64'h11);
    wr(4'h7, 8'h40);
    wr(4'h1, 8'h01);
    chk("R5 port1 after unlock", 64'(pad_drive_low[15:8]), 64'h01);
    wr(4'h1, 8'h00);
    wr(4'h2, 8'h00);
    wr(4'h5, 8'h00);
    ext_lvl[15:8] = 8'hff;

    // R6: bank paging
    wr(4'h8, 8'hf0);
    rd_exp(4'h8, 8'hf0, "R6 pol0");
    wr(4'h7, 8'h80);
    wr(4'h9, 8'h0f);
    rd_exp(4'h9, 8'h0f, "R6 en1");
    wr(4'h7, 8'h00);
    wr(4'h8, 8'h55);
    rd_exp(4'h8, 8'h00, "R6 page0 reads zero");
    rd_exp(4'hb, 8'h00, "R6 offset 11");
    rd_exp(4'hf, 8'h00, "R6 offset 15");
    wr(4'h7, 8'h40);
    rd_exp(4'h8, 8'hf0, "R6 page0 write ignored");
    wr(4'h8, 8'h00);
    wr(4'h7, 8'h80);
    wr(4'h9, 8'h00);

    // R7: polarity-selected edges on enabled lines
    wr(4'h7, 8'h40);
    wr(4'h8, 8'h01);
    wr(4'h7, 8'h80);
    wr(4'h8, 8'h07);
    ext_lvl[0] = 1'b0;
    idle(4);
    chk("R7 opposite edge no irq", 64'(irq), 64'h0);
    ext_lvl[0] = 1'b1;
    idle(4);
    chk("R7 rising sets irq", 64'(irq), 64'h1);
    wr(4'h7, 8'hc0);
    rd_exp(4'h8, 8'h01, "R7 rising flag");
    ext_lvl[1] = 1'b0;
    idle(4);
    rd_exp(4'h8, 8'h03, "R7 falling flag");
    ext_lvl[3] = 1'b0;
    idle(4);
    ext_lvl[3] = 1'b1;
    idle(4);
    rd_exp(4'h8, 8'h03, "R7 disabled line");
    rd_exp(4'h6, 8'h01, "R10 pending port0");
    wr(4'h0, 8'h04);
    idle(4);
    rd_exp(4'h8, 8'h07, "R7 own drive edge");
    wr(4'h0, 8'h00);
    idle(4);
    rd_exp(4'h8, 8'h07, "R7 release no flag");

    // R8: acknowledge by writing zeros
    wr(4'h8, 8'hfe);
    rd_exp(4'h8, 8'h06, "R8 clear bit0");
    chk("R8 irq still high", 64'(irq), 64'h1);
    wr(4'h8, 8'h00);
    rd_exp(4'h8, 8'h00, "R8 clear all");
    chk("R8 irq low", 64'(irq), 64'h0);
    rd_exp(4'h6, 8'h00, "R10 pending empty");

    // R10: pending summary for port1
    wr(4'h7, 8'h80);
    wr(4'h9, 8'h01);
    ext_lvl[8] = 1'b0;
    idle(4);
    rd_exp(4'h6, 8'h02, "R10 pending port1");
    chk("R10 irq", 64'(irq), 64'h1);
    wr(4'h7, 8'hc0);
    wr(4'h9, 8'h00);
    ext_lvl[8] = 1'b1;
    idle(4);
    chk("R10 irq after clear", 64'(irq), 64'h0);

    // R11: upper lines never interrupt
    ext_lvl[30] = 1'b0;
    idle(4);
    ext_lvl[47] = 1'b0;
    idle(4);
    ext_lvl[30] = 1'b1;
    ext_lvl[47] = 1'b1;
    idle(4);
    chk("R11 irq", 64'(irq), 64'h0);
    rd_exp(4'h6, 8'h00, "R11 pending");

    // R9: clear write lands on the cycle a new edge is latched
    ext_lvl[1] = 1'b1;
    idle(4);
    ext_lvl[1] = 1'b0;
    idle(4);
    ext_lvl[0] = 1'b0;
    idle(4);
    rd_exp(4'h8, 8'h02, "R9 setup flag1");
    ext_lvl[0] = 1'b1;
    idle(2);
    wr(4'h8, 8'h00);
    idle(1);
    rd_exp(4'h8, 8'h01, "R9 new edge wins");
    chk("R9 irq", 64'(irq), 64'h1);
    wr(4'h8, 8'h00);
    rd_exp(4'h8, 8'h00, "R9 final clear");

    idle(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule